// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a target device has left holding SDA low, for example after a controller reset in the middle of a read. On a trigger it looks at the present SCL and SDA levels. If both lines are already high, the bus is healthy. The block then finishes at once, does not touch the lines, and reports success.

If either line is low, the block clocks the bus by hand, one SCL pulse at a time. After each pulse it waits a fixed time and then samples SDA. Once SDA reads high, the target has let go. The block then places a START condition on the bus, holds it, releases SDA to form a STOP, and waits a long settle time before it reports success. If SDA is still low after the last permitted pulse, the block reports failure and never drives SDA.

Both outputs drive the lines open-drain: a 1 on an output pulls its line low. Every sequence ends with a one-cycle done strobe and a one-cycle reset request for the bus controller. All delays are whole microseconds, counted in clock cycles through a clocks-per-microsecond parameter.

Top module: `i2c_unstick_seq`

## Requirements
- R1: When a trigger arrives with scl_in and sda_in both high, done and ok are high in the next cycle, and neither line is driven at any point in the sequence.
- R2: Each recovery pulse drives scl_low high for exactly SCL_HALF_CYC cycles, then releases it for at least SCL_HALF_CYC cycles. SCL and SDA are never driven in the same cycle.
- R3: SDA is sampled PULSE_WAIT_US*CLK_PER_US cycles after each pulse ends. Pulsing stops at the first sample that reads high, so the number of pulses equals the number the target needs to let go.
- R4: At most MAX_PULSES (default 28) pulses are issued. If SDA is still low after the last one, done comes with ok low, and sda_low is never asserted during that sequence.
- R5: After SDA is released, a START is made by driving sda_low with SCL released. It is held for exactly START_HOLD_US*CLK_PER_US cycles, and then SDA is released to form the STOP.
- R6: From the STOP to the done strobe, SETTLE_US*CLK_PER_US cycles pass with both lines released, and ok is high with done.
- R7: done is a one-cycle strobe issued exactly once per sequence. ctrl_reset is a one-cycle pulse issued exactly once per sequence, whether the sequence succeeds or fails.
- R8: A trigger that arrives while busy is high has no effect on the pulse count, the START, or the number of done strobes.
- R9: After reset, busy, done, ok, ctrl_reset, scl_low and sda_low are all low. Outside a sequence, neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trigger | input | 1 | Starts a recovery sequence when idle |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_low | output | 1 | 1 pulls SCL low (open-drain) |
| sda_low | output | 1 | 1 pulls SDA low (open-drain) |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence strobe |
| ok | output | 1 | Valid with done: 1 bus freed, 0 failed |
| ctrl_reset | output | 1 | One-cycle reset request to the bus controller |

## Verification
The bench models a target that lets go of SDA only after a chosen number of SCL rising edges. It covers zero (a clean bus), one, exactly the limit, one past the limit, and random counts in between. A design that stops one pulse short or one pulse late would show a wrong pulse count or a wrong ok at the limit. A design that drove SDA after a failure would show a nonzero START length. The bench also holds SCL stuck low with SDA high, which must still produce exactly one pulse. It fires a second trigger in the middle of a sequence, which must not start another sequence or add a second done. It measures each pulse width, the START hold and the settle time in cycles, so a timer that is off by one shows up directly.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCL_LOW,
        ST_SCL_HIGH,
        ST_SAMPLE_WAIT,
        ST_START_HOLD,
        ST_SETTLE,
        ST_FINISH
    } seq_state_t;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
        logic busy;
        logic done;
        logic ctrl_reset;
    } line_ctl_t;

    function automatic int us_to_cyc(input int us, input int clk_per_us);
        return us * clk_per_us;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic line_ctl_t ctl_for(input seq_state_t s);
        line_ctl_t c;
        c.scl_low    = (s == ST_SCL_LOW);
        c.sda_low    = (s == ST_START_HOLD);
        c.busy       = (s != ST_IDLE);
        c.done       = (s == ST_FINISH);
        c.ctrl_reset = (s == ST_FINISH);
        return c;
    endfunction

endpackage

// File: rtl/i2c_unstick_timer.sv
module i2c_unstick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ld) begin
            cnt_q <= ld_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/i2c_unstick_pulse_cnt.sv
module i2c_unstick_pulse_cnt #(
    parameter int MAX_PULSES = 28
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(MAX_PULSES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_PULSES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr && !inc) begin
            cnt_q <= '0;
        end else if (clr && inc) begin
            cnt_q <= CW'(1);
        end else if (inc && cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q == LIMIT);
endmodule

// File: rtl/i2c_unstick_fsm.sv
module i2c_unstick_fsm
    import i2c_unstick_pkg::*;
#(
    parameter int TW        = 8,
    parameter int HALF_CYC  = 2,
    parameter int WAIT_CYC  = 40,
    parameter int START_CYC = 40,
    parameter int SETTLE_CYC = 400
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trigger,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic          tmr_expired,
    input  logic          cnt_at_limit,
    output logic          tmr_ld,
    output logic [TW-1:0] tmr_val,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output line_ctl_t     ctl,
    output logic          ok_flag
);
    localparam logic [TW-1:0] HALF_LD   = TW'(HALF_CYC - 1);
    localparam logic [TW-1:0] WAIT_LD   = TW'(WAIT_CYC - 1);
    localparam logic [TW-1:0] START_LD  = TW'(START_CYC - 1);
    localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);

    seq_state_t st_q, st_nxt;
    logic       ok_q, ok_nxt;
    line_ctl_t  ctl_q;

    always_comb begin
        st_nxt  = st_q;
        ok_nxt  = ok_q;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (trigger) begin
                    cnt_clr = 1'b1;
                    if (scl_in && sda_in) begin
                        st_nxt = ST_FINISH;
                        ok_nxt = 1'b1;
                    end else begin
                        st_nxt  = ST_SCL_LOW;
                        ok_nxt  = 1'b0;
                        tmr_ld  = 1'b1;
                        tmr_val = HALF_LD;
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_SCL_LOW: begin
                if (tmr_expired) begin
                    st_nxt  = ST_SCL_HIGH;
                    tmr_ld  = 1'b1;
                    tmr_val = HALF_LD;
                end
            end
            ST_SCL_HIGH: begin
                if (tmr_expired) begin
                    st_nxt  = ST_SAMPLE_WAIT;
                    tmr_ld  = 1'b1;
                    tmr_val = WAIT_LD;
                end
            end
            ST_SAMPLE_WAIT: begin
                if (tmr_expired) begin
                    if (sda_in) begin
                        st_nxt  = ST_START_HOLD;
                        tmr_ld  = 1'b1;
                        tmr_val = START_LD;
                    end else if (cnt_at_limit) begin
                        st_nxt = ST_FINISH;
                        ok_nxt = 1'b0;
                    end else begin
                        st_nxt  = ST_SCL_LOW;
                        tmr_ld  = 1'b1;
                        tmr_val = HALF_LD;
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_START_HOLD: begin
                if (tmr_expired) begin
                    st_nxt  = ST_SETTLE;
                    tmr_ld  = 1'b1;
                    tmr_val = SETTLE_LD;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    st_nxt = ST_FINISH;
                    ok_nxt = 1'b1;
                end
            end
            ST_FINISH: st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            ok_q  <= 1'b0;
            ctl_q <= '0;
        end else begin
            st_q  <= st_nxt;
            ok_q  <= ok_nxt;
            ctl_q <= ctl_for(st_nxt);
        end
    end

    assign ctl     = ctl_q;
    assign ok_flag = ok_q;
endmodule

// File: rtl/i2c_unstick_seq.sv
module i2c_unstick_seq
    import i2c_unstick_pkg::*;
#(
    parameter int CLK_PER_US    = 250,
    parameter int SCL_HALF_CYC  = 1250,
    parameter int PULSE_WAIT_US = 20,
    parameter int START_HOLD_US = 20,
    parameter int SETTLE_US     = 200,
    parameter int MAX_PULSES    = 28
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_low,
    output logic sda_low,
    output logic busy,
    output logic done,
    output logic ok,
    output logic ctrl_reset
);
    localparam int WAIT_CYC   = us_to_cyc(PULSE_WAIT_US, CLK_PER_US);
    localparam int START_CYC  = us_to_cyc(START_HOLD_US, CLK_PER_US);
    localparam int SETTLE_CYC = us_to_cyc(SETTLE_US, CLK_PER_US);
    localparam int MAX_CYC    = max3(max3(WAIT_CYC, START_CYC, SETTLE_CYC), SCL_HALF_CYC, 1);
    localparam int TW         = $clog2(MAX_CYC + 1);

    logic          tmr_ld, tmr_expired;
    logic [TW-1:0] tmr_val;
    logic          cnt_clr, cnt_inc, cnt_at_limit;
    line_ctl_t     ctl;
    logic          ok_flag;

    i2c_unstick_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .ld      (tmr_ld),
        .ld_val  (tmr_val),
        .expired (tmr_expired)
    );

    i2c_unstick_pulse_cnt #(.MAX_PULSES(MAX_PULSES)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .at_limit (cnt_at_limit)
    );

    i2c_unstick_fsm #(
        .TW         (TW),
        .HALF_CYC   (SCL_HALF_CYC),
        .WAIT_CYC   (WAIT_CYC),
        .START_CYC  (START_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .trigger      (trigger),
        .scl_in       (scl_in),
        .sda_in       (sda_in),
        .tmr_expired  (tmr_expired),
        .cnt_at_limit (cnt_at_limit),
        .tmr_ld       (tmr_ld),
        .tmr_val      (tmr_val),
        .cnt_clr      (cnt_clr),
        .cnt_inc      (cnt_inc),
        .ctl          (ctl),
        .ok_flag      (ok_flag)
    );

    assign scl_low    = ctl.scl_low;
    assign sda_low    = ctl.sda_low;
    assign busy       = ctl.busy;
    assign done       = ctl.done;
    assign ctrl_reset = ctl.ctrl_reset;
    assign ok         = ctl.done & ok_flag;
endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk #(
    parameter int MAX_PULSES = 28
) (
    input logic clk,
    input logic rst,
    input logic trigger,
    input logic scl_in,
    input logic sda_in,
    input logic scl_low,
    input logic sda_low,
    input logic busy,
    input logic done,
    input logic ok,
    input logic ctrl_reset
);
    localparam int CW = $clog2(MAX_PULSES + 2);

    logic [CW-1:0] pulses_q;
    logic          prev_scl_q;
    logic          sda_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulses_q   <= '0;
            prev_scl_q <= 1'b0;
            sda_seen_q <= 1'b0;
        end else begin
            prev_scl_q <= scl_low;
            if (!busy && trigger) begin
                pulses_q   <= '0;
                sda_seen_q <= 1'b0;
            end else begin
                if (scl_low && !prev_scl_q && pulses_q != '1) pulses_q <= pulses_q + 1'b1;
                if (sda_low) sda_seen_q <= 1'b1;
            end
        end
    end

    AST_CLEAN_FAST: assert property (@(posedge clk) disable iff (rst)
        (!busy && trigger && scl_in && sda_in) |=> (done && ok)); // R1
    AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !(scl_low && sda_low)); // R2
    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        pulses_q <= CW'(MAX_PULSES)); // R4
    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (done && !ok && pulses_q != '0) |-> (!sda_seen_q && pulses_q == CW'(MAX_PULSES))); // R4
    AST_DONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_RESET_STROBE: assert property (@(posedge clk) disable iff (rst)
        ctrl_reset |=> !ctrl_reset); // R7
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_low && !sda_low)); // R9
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R8
endmodule

bind i2c_unstick_seq i2c_unstick_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .trigger    (trigger),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .scl_low    (scl_low),
    .sda_low    (sda_low),
    .busy       (busy),
    .done       (done),
    .ok         (ok),
    .ctrl_reset (ctrl_reset)
);

// File: tb/tb_i2c_unstick_seq.sv
module tb_i2c_unstick_seq;
    localparam int CPU    = 2;
    localparam int HALF   = 3;
    localparam int WAITU  = 20;
    localparam int STARTU = 20;
    localparam int SETU   = 200;
    localparam int MAXP   = 28;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trigger = 1'b0;
    logic scl_low, sda_low, busy, done, ok, ctrl_reset;

    logic slave_hold = 1'b0;
    logic slave_scl_stuck = 1'b0;
    int   release_after = 0;
    int   seen_edges = 0;
    logic scl_bus, sda_bus, scl_bus_prev;

    assign scl_bus = !scl_low && !slave_scl_stuck;
    assign sda_bus = !sda_low && !slave_hold;

    i2c_unstick_seq #(
        .CLK_PER_US(CPU), .SCL_HALF_CYC(HALF), .PULSE_WAIT_US(WAITU),
        .START_HOLD_US(STARTU), .SETTLE_US(SETU), .MAX_PULSES(MAXP)
    ) dut (
        .clk(clk), .rst(rst), .trigger(trigger), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_low(scl_low), .sda_low(sda_low), .busy(busy), .done(done), .ok(ok),
        .ctrl_reset(ctrl_reset)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // target model: releases SDA after release_after SCL rising edges
    always @(posedge clk) begin
        cycles <= cycles + 1;
        scl_bus_prev <= scl_bus;
        if (scl_bus && !scl_bus_prev && slave_hold) begin
            seen_edges <= seen_edges + 1;
            if (seen_edges + 1 >= release_after) slave_hold <= 1'b0;
        end
    end

    // monitor, sampled at negedge
    int  m_pulses, m_width_err, m_sda_len, m_settle, m_settle_rec, m_done, m_rstp, m_dual;
    logic m_ok_rec, m_prev_scl, m_prev_sda, m_settle_act;
    int  m_cur_w;

    always @(negedge clk) begin
        if (scl_low && !m_prev_scl) begin m_pulses++; m_cur_w = 0; end
        if (scl_low) m_cur_w++;
        if (!scl_low && m_prev_scl && m_cur_w != HALF) m_width_err++;
        if (sda_low) m_sda_len++;
        if (scl_low && sda_low) m_dual++;
        if (m_prev_sda && !sda_low) begin m_settle = 1; m_settle_act = 1'b1; end
        else if (m_settle_act && !done) m_settle++;
        if (done) begin
            m_done++; m_ok_rec = ok;
            if (m_settle_act) begin m_settle_rec = m_settle; m_settle_act = 1'b0; end
        end
        if (ctrl_reset) m_rstp++;
        m_prev_scl = scl_low;
        m_prev_sda = sda_low;
    end

    task automatic mon_clear();
        m_pulses = 0; m_width_err = 0; m_sda_len = 0; m_settle = 0; m_settle_rec = -1;
        m_done = 0; m_rstp = 0; m_dual = 0; m_ok_rec = 1'b0; m_settle_act = 1'b0; m_cur_w = 0;
    endtask

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_pulses(input int k);
        return (k > MAXP) ? MAXP : k;
    endfunction
    function automatic int exp_ok(input int k);
        return (k <= MAXP) ? 1 : 0;
    endfunction

    task automatic wait_done(input int extra_trig_at);
        int n = 0;
        while (m_done == 0 && n < 5000) begin
            @(negedge clk);
            n++;
            if (n == extra_trig_at) trigger = 1'b1;
            else trigger = 1'b0;
        end
        trigger = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    task automatic run_case(input int k, input bit stuck_scl, input int extra_trig_at);
        int ep, eo;
        @(negedge clk);
        mon_clear();
        release_after = k;
        seen_edges = 0;
        slave_hold = (k > 0);
        slave_scl_stuck = stuck_scl;
        @(negedge clk);
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        if (k == 0 && !stuck_scl) begin
            chk(done === 1'b1 && ok === 1'b1, "R1 clean bus done+ok next cycle", {done, ok}, 3);
        end
        wait_done(extra_trig_at);
        slave_scl_stuck = 1'b0;
        ep = stuck_scl ? 1 : exp_pulses(k);
        eo = stuck_scl ? 1 : exp_ok(k);
        chk(m_pulses == ep, "R3/R4 pulse count", m_pulses, ep);
        chk(m_width_err == 0, "R2 pulse width", m_width_err, 0);
        chk(m_dual == 0, "R2 dual drive", m_dual, 0);
        chk(int'(m_ok_rec) == eo, "R4/R6 ok with done", int'(m_ok_rec), eo);
        chk(m_done == 1, "R7 done count", m_done, 1);
        chk(m_rstp == 1, "R7 ctrl_reset count", m_rstp, 1);
        if (k == 0 && !stuck_scl) begin
            chk(m_sda_len == 0, "R1 no SDA drive on clean bus", m_sda_len, 0);
        end else if (eo == 1) begin
            chk(m_sda_len == STARTU * CPU, "R5 START hold length", m_sda_len, STARTU * CPU);
            chk(m_settle_rec == SETU * CPU, "R6 settle length", m_settle_rec, SETU * CPU);
        end else begin
            chk(m_sda_len == 0, "R4 no START on failure", m_sda_len, 0);
        end
        if (extra_trig_at > 0)
            chk(m_done == 1 && m_pulses == ep, "R8 trigger while busy ignored", m_done, 1);
        chk(busy === 1'b0 && scl_low === 1'b0 && sda_low === 1'b0, "R9 idle released",
            {busy, scl_low, sda_low}, 0);
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h1CB3;
        void'($urandom(seed));
        mon_clear();
        m_prev_scl = 1'b0; m_prev_sda = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && ok === 1'b0 && ctrl_reset === 1'b0 &&
            scl_low === 1'b0 && sda_low === 1'b0, "R9 reset state",
            {busy, done, ok, ctrl_reset, scl_low, sda_low}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && scl_low === 1'b0, "R9 idle after reset", {busy, scl_low}, 0);

        run_case(0, 1'b0, 0);      // R1 clean bus
        run_case(1, 1'b0, 0);      // R3 single pulse
        run_case(MAXP, 1'b0, 0);   // R4 exactly at limit succeeds
        run_case(MAXP + 1, 1'b0, 0); // R4 one past limit fails
        run_case(0, 1'b1, 0);      // R3 SCL stuck, SDA high: one pulse
        run_case(5, 1'b0, 30);     // R8 second trigger mid-sequence
        run_case(40, 1'b0, 100);   // R8 during failing run
        for (int i = 0; i < 8; i++) begin
            run_case(1 + int'($urandom % 34), 1'b0, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule